// File: doc/BRIEF.md
# Clock-Activity Power and Mode Controller

This controller sits beside a voice codec's serial port. It watches four input pins that each serve two roles: the transmit frame sync, the receive frame sync, the receive master-clock pin (which also acts as a power-down request), and the receive bit-clock pin (which also selects a frequency). Each pin is first brought into the system clock domain. A timeout counter then classifies it as clocking or static, and only after that is the pin's level given a meaning.

From those classifications the block picks one of three operating modes: powered down, full duplex, or receive half-channel. It also chooses which master clock drives internal sequencing. When the receive bit clock is held static, the block decodes the master-clock frequency that the static level selects. All three results are registered. A new clock-source choice takes effect only on a frame boundary, so sequencing never switches clocks in the middle of a frame.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 2'b00 (powered down), clk_src_o is 0 (transmit master clock) and freq_sel_o is 2'b00.
- R2: The two frame-sync pins count as active when they toggle within FS_TIMEOUT system cycles. The master-clock pin and the bit-clock pin count as clocking when they toggle within CLK_TIMEOUT cycles. Any pin that does not toggle within its timeout is static at its synchronized level.
- R3: When the master-clock/power-down pin is static high, mode_o becomes 2'b00, whatever the frame syncs are doing.
- R4: When both frame syncs are absent, mode_o becomes 2'b00, even if the power-down pin is low or clocking.
- R5: When the transmit frame sync is active and the power-down pin is static low or clocking, mode_o becomes 2'b01 (full duplex).
- R6: When the transmit frame sync is absent, the receive frame sync is active and the power-down pin is not static high, mode_o becomes 2'b10 (receive half-channel).
- R7: The desired clock source is 1 (receive master clock) only in receive half-channel mode with the power-down pin clocking. In every other case it is 0 (transmit master clock).
- R8: clk_src_o takes the desired value only on a synchronized rising edge of either frame sync. Between such edges it holds its value.
- R9: freq_sel_o is 2'b00 while the bit-clock pin is clocking. It is 2'b01 (1.536/1.544 MHz) when that pin is static low, and 2'b10 (2.048 MHz) when it is static high.
- R10: mode_o never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_tx_i | input | 1 | Transmit frame sync pin |
| fs_rx_i | input | 1 | Receive frame sync pin |
| rx_mclk_pwr_i | input | 1 | Receive master clock or static power-down request |
| rx_bclk_sel_i | input | 1 | Receive bit clock or static frequency select |
| mode_o | output | 2 | 00 powered down, 01 full duplex, 10 receive half-channel |
| clk_src_o | output | 1 | 0 transmit master clock, 1 receive master clock |
| freq_sel_o | output | 2 | 00 bit clock in use, 01 1.536/1.544 MHz, 10 2.048 MHz |

## Verification
The bench builds the block with FS_TIMEOUT of 200 and CLK_TIMEOUT of 16. Frame syncs pulse every 40 cycles, and the clock pins toggle every two or three cycles. These short timeouts let a frame sync be declared absent within a few hundred cycles. They also leave room to pause the receive frame sync for about 75 cycles without it timing out. During such a pause the power pin can be made static, which shows that the clock source holds until the next frame edge and then switches.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_DOWN   = 2'b00,
    MODE_FULL   = 2'b01,
    MODE_RXHALF = 2'b10
  } pm_mode_e;

  typedef enum logic {
    SRC_TX = 1'b0,
    SRC_RX = 1'b1
  } pm_src_e;

  typedef enum logic [1:0] {
    FREQ_NONE = 2'b00,
    FREQ_LOW  = 2'b01,
    FREQ_HIGH = 2'b10
  } pm_freq_e;

  localparam int unsigned PIN_TX   = 0;
  localparam int unsigned PIN_RX   = 1;
  localparam int unsigned PIN_PWR  = 2;
  localparam int unsigned PIN_SEL  = 3;
  localparam int unsigned NUM_PINS = 4;
endpackage

// File: rtl/pwr_mode_sync.sv
module pwr_mode_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic toggle_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq     <= '0;
      prev_q <= 1'b0;
    end else begin
      sq     <= {sq[STAGES-2:0], d_i};
      prev_q <= sq[STAGES-1];
    end
  end

  assign lvl_o    = sq[STAGES-1];
  assign toggle_o = sq[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pwr_mode_activity.sv
module pwr_mode_activity #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  // starts static; any toggle restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= LAST;
      active_o <= 1'b0;
    end else if (toggle_i) begin
      cnt_q    <= '0;
      active_o <= 1'b1;
    end else if (cnt_q == LAST) begin
      active_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_decide.sv
module pwr_mode_decide
  import pwr_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tx_act_i,
  input  logic     rx_act_i,
  input  logic     pwr_act_i,
  input  logic     pwr_lvl_i,
  input  logic     sel_act_i,
  input  logic     sel_lvl_i,
  input  logic     frame_edge_i,
  output pm_mode_e mode_o,
  output pm_src_e  src_o,
  output pm_freq_e freq_o
);
  logic     pdn;
  pm_mode_e mode_d;
  pm_src_e  src_d;
  pm_freq_e freq_d;

  always_comb begin
    pdn = (!pwr_act_i && pwr_lvl_i) || (!tx_act_i && !rx_act_i);
    if (pdn)           mode_d = MODE_DOWN;
    else if (tx_act_i) mode_d = MODE_FULL;
    else               mode_d = MODE_RXHALF;
    src_d  = (mode_d == MODE_RXHALF && pwr_act_i) ? SRC_RX : SRC_TX;
    freq_d = sel_act_i ? FREQ_NONE : (sel_lvl_i ? FREQ_HIGH : FREQ_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_DOWN;
      src_o  <= SRC_TX;
      freq_o <= FREQ_NONE;
    end else begin
      mode_o <= mode_d;
      freq_o <= freq_d;
      if (frame_edge_i) src_o <= src_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned FS_TIMEOUT  = 32768,
  parameter int unsigned CLK_TIMEOUT = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fs_tx_i,
  input  logic       fs_rx_i,
  input  logic       rx_mclk_pwr_i,
  input  logic       rx_bclk_sel_i,
  output logic [1:0] mode_o,
  output logic       clk_src_o,
  output logic [1:0] freq_sel_o
);
  logic [NUM_PINS-1:0] pin_w, lvl_w, tgl_w, act_w;
  logic                frame_edge;
  pm_mode_e            mode_q;
  pm_src_e             src_q;
  pm_freq_e            freq_q;

  assign pin_w[PIN_TX]  = fs_tx_i;
  assign pin_w[PIN_RX]  = fs_rx_i;
  assign pin_w[PIN_PWR] = rx_mclk_pwr_i;
  assign pin_w[PIN_SEL] = rx_bclk_sel_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int unsigned TO = (i == PIN_TX || i == PIN_RX) ? FS_TIMEOUT : CLK_TIMEOUT;

    pwr_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .d_i      (pin_w[i]),
      .lvl_o    (lvl_w[i]),
      .toggle_o (tgl_w[i])
    );

    pwr_mode_activity #(.TIMEOUT(TO)) u_act (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .toggle_i (tgl_w[i]),
      .active_o (act_w[i])
    );
  end

  // a toggle seen at a high level is a rising edge
  assign frame_edge = (tgl_w[PIN_TX] & lvl_w[PIN_TX]) | (tgl_w[PIN_RX] & lvl_w[PIN_RX]);

  pwr_mode_decide u_decide (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_act_i     (act_w[PIN_TX]),
    .rx_act_i     (act_w[PIN_RX]),
    .pwr_act_i    (act_w[PIN_PWR]),
    .pwr_lvl_i    (lvl_w[PIN_PWR]),
    .sel_act_i    (act_w[PIN_SEL]),
    .sel_lvl_i    (lvl_w[PIN_SEL]),
    .frame_edge_i (frame_edge),
    .mode_o       (mode_q),
    .src_o        (src_q),
    .freq_o       (freq_q)
  );

  assign mode_o     = mode_q;
  assign clk_src_o  = src_q;
  assign freq_sel_o = freq_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       clk_src_o,
  input logic [1:0] freq_sel_o,
  input logic       frame_edge,
  input logic [3:0] act_w,
  input logic [3:0] lvl_w
);
  assert_mode_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  assert_src_on_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_src_o) |-> $past(frame_edge));

  assert_pdn_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_w[2] && lvl_w[2]) |=> mode_o == 2'b00);

  assert_full_duplex_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_w[0] && !(!act_w[2] && lvl_w[2])) |=> mode_o == 2'b01);

  assert_freq_clocking_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_w[3] |=> freq_sel_o == 2'b00);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_o     (mode_o),
  .clk_src_o  (clk_src_o),
  .freq_sel_o (freq_sel_o),
  .frame_edge (frame_edge),
  .act_w      (act_w),
  .lvl_w      (lvl_w)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs_tx = 1'b0, fs_rx = 1'b0, mclk = 1'b0, bclk = 1'b0;
  logic [1:0] mode, freq;
  logic       src;

  logic tx_run = 1'b0, rx_run = 1'b0, mclk_run = 1'b0, bclk_run = 1'b0;
  logic mclk_hold = 1'b0, bclk_hold = 1'b0;
  int   checks = 0, failures = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.FS_TIMEOUT(200), .CLK_TIMEOUT(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fs_tx_i(fs_tx), .fs_rx_i(fs_rx),
    .rx_mclk_pwr_i(mclk), .rx_bclk_sel_i(bclk),
    .mode_o(mode), .clk_src_o(src), .freq_sel_o(freq)
  );

  initial forever begin
    @(posedge clk); #1;
    if (tx_run) begin
      fs_tx = 1'b1; repeat (8) @(posedge clk); #1;
      fs_tx = 1'b0; repeat (31) @(posedge clk);
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (rx_run) begin
      fs_rx = 1'b1; repeat (8) @(posedge clk); #1;
      fs_rx = 1'b0; repeat (31) @(posedge clk);
    end
  end

  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      if (mclk_run) begin
        if (ph == 1) mclk = ~mclk;
        ph = 1 - ph;
      end else mclk = mclk_hold;
    end
  end

  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      if (bclk_run) begin
        if (ph == 2) begin bclk = ~bclk; ph = 0; end else ph = ph + 1;
      end else bclk = bclk_hold;
    end
  end

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 mode", mode, 2'b00);
    chk("R1 src", {1'b0, src}, 2'b00);
    chk("R1 freq", freq, 2'b00);
    chk("R10 mode legal", {1'b0, mode == 2'b11}, 2'b00);
  endtask

  task automatic t_full_low;
    mclk_run = 1'b0; mclk_hold = 1'b0; tx_run = 1'b1; rx_run = 1'b1;
    wait_cyc(300);
    chk("R5 full with pwr low", mode, 2'b01);
    chk("R7 src tx in full", {1'b0, src}, 2'b00);
  endtask

  task automatic t_full_clocking;
    mclk_run = 1'b1;
    wait_cyc(100);
    chk("R2 R5 full with pwr clocking", mode, 2'b01);
    chk("R7 src tx in full clocking", {1'b0, src}, 2'b00);
  endtask

  task automatic t_rx_half;
    tx_run = 1'b0;
    wait_cyc(300);
    chk("R6 rx half", mode, 2'b10);
    chk("R7 src rx in half", {1'b0, src}, 2'b01);
  endtask

  task automatic t_src_boundary;
    rx_run = 1'b0;
    wait_cyc(45);
    mclk_run = 1'b0; mclk_hold = 1'b0;
    wait_cyc(30);
    chk("R6 still rx half", mode, 2'b10);
    chk("R8 src holds without frame edge", {1'b0, src}, 2'b01);
    rx_run = 1'b1;
    wait_cyc(30);
    chk("R8 src switches at frame edge", {1'b0, src}, 2'b00);
    chk("R6 rx half after resume", mode, 2'b10);
  endtask

  task automatic t_pdn_high;
    tx_run = 1'b1; mclk_run = 1'b0; mclk_hold = 1'b1;
    wait_cyc(100);
    chk("R3 R2 down with pwr static high", mode, 2'b00);
    chk("R7 src tx when down", {1'b0, src}, 2'b00);
  endtask

  task automatic t_no_sync;
    mclk_hold = 1'b0; mclk_run = 1'b1; tx_run = 1'b0; rx_run = 1'b0;
    wait_cyc(300);
    chk("R4 down with no frame sync", mode, 2'b00);
    tx_run = 1'b1;
    wait_cyc(60);
    chk("R5 full after tx sync returns", mode, 2'b01);
  endtask

  task automatic t_freq;
    bclk_run = 1'b1;
    wait_cyc(40);
    chk("R9 freq none while clocking", freq, 2'b00);
    bclk_run = 1'b0; bclk_hold = 1'b0;
    wait_cyc(40);
    chk("R9 freq low static", freq, 2'b01);
    bclk_hold = 1'b1;
    wait_cyc(40);
    chk("R9 freq high static", freq, 2'b10);
    chk("R10 mode legal end", {1'b0, mode == 2'b11}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    #1 rst_n = 1'b1;
    t_full_low;
    t_full_clocking;
    t_rx_half;
    t_src_boundary;
    t_pdn_high;
    t_no_sync;
    t_freq;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule